// File: doc/BRIEF.md
# Ready-Line Handshake Controller (Slave Side)

This block runs the slave half of a two-wire wake-and-ready handshake that brackets every serial transaction between a host and a peripheral processor. Both ready lines are active-low. The master's ready line comes in as an asynchronous input. The block drives the slave's ready line, opens the window in which the byte engine may move data, and records which side started the exchange.

Either side may open a window. The master can pull its line low, or the local logic can raise a send request. The block arms its own receive path before it pulls its ready line low. It lets data move only while both lines are low. When the master lets its line go high, the block releases its own line after it. A byte engine sits beside this controller. It uses the transfer-enable strobe to clock or shift bytes and reports the end of its work through a done pulse. Because the window is bidirectional, a slave send request that collides with a master wake-up is carried inside the master's window.

Top module: `rdy_handshake_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `srdy_n_o` is 1, and `xfer_en_o`, `rx_arm_o` and `slave_init_o` are 0.
- R2: The master-ready input passes through a two-stage synchronizer. After `mrdy_n_i` falls in an idle block, no output changes on the first two rising clock edges.
- R3: `rx_arm_o` goes to 1 at least one cycle before `srdy_n_o` goes low, and it stays at 1 for as long as `srdy_n_o` is low.
- R4: A `send_req_i` seen in idle, with the master line high, sets `rx_arm_o` on the next edge. It drives `srdy_n_o` low and sets `slave_init_o` to 1 one edge later.
- R5: A window started by the master (`mrdy_n_i` falling in idle) drives `srdy_n_o` low on the fourth rising edge after the fall, with `slave_init_o` equal to 0.
- R6: `xfer_en_o` is 1 only while `srdy_n_o` is low and the synchronized master line is low. While the slave waits for the master, `xfer_en_o` stays 0. It rises on the third edge after `mrdy_n_i` falls.
- R7: Two edges after `mrdy_n_i` rises in an open window, `xfer_en_o` is 0. On the third edge `srdy_n_o` returns to 1. On the fourth edge the block is idle, with `rx_arm_o` and `slave_init_o` at 0.
- R8: A `xfer_done_i` pulse during an open window forces `xfer_en_o` to 0 from the next edge until the window closes.
- R9: If the synchronized master line and `send_req_i` are first seen together in idle, the window counts as started by the master (`slave_init_o` = 0). It opens on the following edge with `xfer_en_o` = 1, so the pending slave data can go out in the same window.
- R10: A `send_req_i` outside idle is ignored. It changes neither `slave_init_o` nor `srdy_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mrdy_n_i | input | 1 | Master ready line, active-low, asynchronous |
| send_req_i | input | 1 | Local request to send an indication |
| xfer_done_i | input | 1 | End-of-transfer pulse from the byte engine |
| srdy_n_o | output | 1 | Slave ready line, active-low |
| xfer_en_o | output | 1 | Data movement permitted |
| rx_arm_o | output | 1 | Receive path armed |
| slave_init_o | output | 1 | 1 when the current window was started by the slave |

## Verification
The assertions assume that `mrdy_n_i` stays steady for at least three cycles around each of its edges. They also assume that the master does not pull its line low again inside the cycle in which the slave line is being released, and that `xfer_done_i` only pulses while the window is open. The bench drives every input on the falling clock edge. It holds each master-line level for several cycles, pulses the done input only while the transfer enable is high, and waits until the block is idle before it starts a new scenario.

// File: rtl/rdy_hs_pkg.sv
package rdy_hs_pkg;
  typedef enum logic [2:0] {
    HS_IDLE      = 3'd0,
    HS_ARMED     = 3'd1,
    HS_SLAVE_REQ = 3'd2,
    HS_ACTIVE    = 3'd3,
    HS_CLOSING   = 3'd4
  } hs_state_e;

  localparam int unsigned HS_SYNC_STAGES = 2;
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  // first stage samples the raw line, later stages shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RESET_VAL;
    else        chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= RESET_VAL;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/rdy_hs_fsm.sv
module rdy_hs_fsm
  import rdy_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      m_act_i,
  input  logic      send_req_i,
  input  logic      xfer_done_i,
  output hs_state_e state_o,
  output logic      slave_init_o,
  output logic      done_o
);
  hs_state_e st_q, st_d;
  logic      init_q, init_d;
  logic      done_q, done_d;
  logic      st_en, init_en, done_en;

  // next-state process
  always_comb begin
    st_d   = st_q;
    init_d = init_q;
    done_d = done_q;
    unique case (st_q)
      HS_IDLE: begin
        if (m_act_i) begin
          st_d   = HS_ARMED;      // master wins a tie with a local request
          init_d = 1'b0;
          done_d = 1'b0;
        end else if (send_req_i) begin
          st_d   = HS_ARMED;
          init_d = 1'b1;
          done_d = 1'b0;
        end
      end
      HS_ARMED:     st_d = init_q ? HS_SLAVE_REQ : HS_ACTIVE;
      HS_SLAVE_REQ: if (m_act_i) st_d = HS_ACTIVE;
      HS_ACTIVE: begin
        if (xfer_done_i) done_d = 1'b1;
        if (!m_act_i)    st_d   = HS_CLOSING;
      end
      HS_CLOSING: begin
        st_d   = HS_IDLE;
        init_d = 1'b0;
        done_d = 1'b0;
      end
      default: begin
        st_d   = HS_IDLE;
        init_d = 1'b0;
        done_d = 1'b0;
      end
    endcase
  end

  assign st_en   = (st_d != st_q);
  assign init_en = (init_d != init_q);
  assign done_en = (done_d != done_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      init_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (init_en) init_q <= init_d;
      if (done_en) done_q <= done_d;
    end
  end

  assign state_o      = st_q;
  assign slave_init_o = init_q;
  assign done_o       = done_q;
endmodule

// File: rtl/rdy_hs_outdec.sv
module rdy_hs_outdec
  import rdy_hs_pkg::*;
(
  input  hs_state_e state_i,
  input  logic      m_act_i,
  input  logic      done_i,
  output logic      srdy_n_o,
  output logic      xfer_en_o,
  output logic      rx_arm_o
);
  logic own_ready;

  assign own_ready = (state_i == HS_SLAVE_REQ) || (state_i == HS_ACTIVE);
  assign srdy_n_o  = ~own_ready;
  assign rx_arm_o  = own_ready || (state_i == HS_ARMED);
  assign xfer_en_o = (state_i == HS_ACTIVE) && m_act_i && !done_i;
endmodule

// File: rtl/rdy_handshake_ctrl.sv
module rdy_handshake_ctrl
  import rdy_hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = HS_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mrdy_n_i,
  input  logic send_req_i,
  input  logic xfer_done_i,
  output logic srdy_n_o,
  output logic xfer_en_o,
  output logic rx_arm_o,
  output logic slave_init_o
);
  logic      mrdy_n_s;
  logic      m_act;
  logic      done;
  hs_state_e state;

  rdy_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mrdy_n_i),
    .q_o   (mrdy_n_s)
  );

  assign m_act = ~mrdy_n_s;

  rdy_hs_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .m_act_i      (m_act),
    .send_req_i   (send_req_i),
    .xfer_done_i  (xfer_done_i),
    .state_o      (state),
    .slave_init_o (slave_init_o),
    .done_o       (done)
  );

  rdy_hs_outdec u_dec (
    .state_i   (state),
    .m_act_i   (m_act),
    .done_i    (done),
    .srdy_n_o  (srdy_n_o),
    .xfer_en_o (xfer_en_o),
    .rx_arm_o  (rx_arm_o)
  );
endmodule

// File: rtl/rdy_hs_checker.sv
module rdy_hs_checker (
  input logic clk,
  input logic rst_n,
  input logic mrdy_n_i,
  input logic send_req_i,
  input logic xfer_done_i,
  input logic srdy_n_o,
  input logic xfer_en_o,
  input logic rx_arm_o,
  input logic slave_init_o
);
  // R1: outputs idle while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_idle_r1: assert (srdy_n_o && !xfer_en_o && !rx_arm_o && !slave_init_o);
    end
  end

  // R3: receive path armed in the cycle before the ready line falls
  p_arm_before_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srdy_n_o) |-> $past(rx_arm_o));

  // R3: receive path stays armed while the ready line is low
  p_arm_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !srdy_n_o |-> rx_arm_o);

  // R6: data moves only with both lines low (master line seen through the sync)
  p_en_needs_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en_o |-> (!srdy_n_o && !$past(mrdy_n_i, 2)));

  // R7: slave line released only after the master has released its own
  p_release_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srdy_n_o) |-> $past(mrdy_n_i));

  // R8: end-of-transfer shuts the enable for the rest of the window
  p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_i && xfer_en_o) |=> !xfer_en_o);

  // R10: initiator flag does not move while the window is held open
  p_init_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!srdy_n_o && $past(!srdy_n_o)) |-> $stable(slave_init_o));
endmodule

bind rdy_handshake_ctrl rdy_hs_checker u_chk (.*);

// File: tb/rdy_handshake_ctrl_bench.sv
module rdy_handshake_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic mrdy_n_i;
  logic send_req_i;
  logic xfer_done_i;
  logic srdy_n_o;
  logic xfer_en_o;
  logic rx_arm_o;
  logic slave_init_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rdy_handshake_ctrl u_rdy_handshake_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mrdy_n_i     (mrdy_n_i),
    .send_req_i   (send_req_i),
    .xfer_done_i  (xfer_done_i),
    .srdy_n_o     (srdy_n_o),
    .xfer_en_o    (xfer_en_o),
    .rx_arm_o     (rx_arm_o),
    .slave_init_o (slave_init_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // advance n rising edges, land on the following falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mrdy_n_i = 1'b1; send_req_i = 1'b0; xfer_done_i = 1'b0;
    step(3);
    chk("R1", "srdy_n in reset", srdy_n_o, 1'b1);
    chk("R1", "xfer_en in reset", xfer_en_o, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "rx_arm after reset", rx_arm_o, 1'b0);
    chk("R1", "slave_init after reset", slave_init_o, 1'b0);
  endtask

  task automatic t_master_init;
    mrdy_n_i = 1'b0;
    step(2);
    chk("R2", "rx_arm after 2 edges", rx_arm_o, 1'b0);
    chk("R2", "srdy_n after 2 edges", srdy_n_o, 1'b1);
    step(1);
    chk("R3", "rx_arm before ready", rx_arm_o, 1'b1);
    chk("R3", "srdy_n still high", srdy_n_o, 1'b1);
    step(1);
    chk("R5", "srdy_n on 4th edge", srdy_n_o, 1'b0);
    chk("R5", "slave_init master window", slave_init_o, 1'b0);
    chk("R6", "xfer_en both low", xfer_en_o, 1'b1);
    send_req_i = 1'b1;
    step(2);
    chk("R10", "slave_init after late request", slave_init_o, 1'b0);
    chk("R10", "srdy_n after late request", srdy_n_o, 1'b0);
    send_req_i = 1'b0;
    xfer_done_i = 1'b1;
    step(1);
    xfer_done_i = 1'b0;
    chk("R8", "xfer_en after done", xfer_en_o, 1'b0);
    step(2);
    chk("R8", "xfer_en stays off", xfer_en_o, 1'b0);
    mrdy_n_i = 1'b1;
    step(2);
    chk("R7", "srdy_n held 2 edges after release", srdy_n_o, 1'b0);
    step(1);
    chk("R7", "srdy_n released 3rd edge", srdy_n_o, 1'b1);
    step(1);
    chk("R7", "rx_arm idle", rx_arm_o, 1'b0);
  endtask

  task automatic t_slave_init;
    send_req_i = 1'b1;
    step(1);
    send_req_i = 1'b0;
    chk("R4", "rx_arm one edge after request", rx_arm_o, 1'b1);
    chk("R3", "srdy_n high while arming", srdy_n_o, 1'b1);
    step(1);
    chk("R4", "srdy_n low second edge", srdy_n_o, 1'b0);
    chk("R4", "slave_init set", slave_init_o, 1'b1);
    chk("R6", "no xfer without master", xfer_en_o, 1'b0);
    step(3);
    chk("R6", "still waiting for master", xfer_en_o, 1'b0);
    mrdy_n_i = 1'b0;
    step(2);
    chk("R6", "xfer_en not yet (sync)", xfer_en_o, 1'b0);
    step(1);
    chk("R6", "xfer_en on 3rd edge", xfer_en_o, 1'b1);
    mrdy_n_i = 1'b1;
    step(1);
    chk("R7", "xfer_en before sync done", xfer_en_o, 1'b1);
    step(1);
    chk("R7", "xfer_en off 2 edges after release", xfer_en_o, 1'b0);
    chk("R7", "srdy_n still low", srdy_n_o, 1'b0);
    step(1);
    chk("R7", "srdy_n released", srdy_n_o, 1'b1);
    step(1);
    chk("R7", "slave_init cleared", slave_init_o, 1'b0);
    chk("R7", "rx_arm cleared", rx_arm_o, 1'b0);
  endtask

  task automatic t_tie;
    mrdy_n_i = 1'b0;
    step(2);
    send_req_i = 1'b1;
    step(1);
    send_req_i = 1'b0;
    chk("R9", "armed on tie", rx_arm_o, 1'b1);
    chk("R9", "tie counted as master", slave_init_o, 1'b0);
    step(1);
    chk("R9", "srdy_n low on tie", srdy_n_o, 1'b0);
    chk("R9", "bidirectional window open", xfer_en_o, 1'b1);
    mrdy_n_i = 1'b1;
    step(4);
    chk("R9", "closed after tie window", srdy_n_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_master_init();
    step(2);
    t_slave_init();
    step(2);
    t_tie();
    step(2);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule